// File: doc/BRIEF.md
# Thermal Trip Shutdown Latch

This block watches a digital die-temperature code and, once the silicon reaches a trip level set a fixed margin above the maximum rated case temperature, drives an active-low thermal-trip output and a clock-halt request that stops execution. The trip is sticky. It holds whatever the temperature does afterwards, and only the loss of power-good or of either supply-valid flag clears it.

Output drive is qualified. It stays off until power-good and both supply flags have been high for a fixed arming window, 10 µs by default, counted in clock cycles. It turns off in the same cycle that any of the three qualifiers drops. A die that is still hot when power returns trips again at the end of the arming window.

Top module: `thermal_trip_latch`

## Requirements
- R1: While `pwr_good` is low, `drive_en` is 0, `thermtrip_n` is 1 and `clk_halt` is 0.
- R2: The block is qualified when `pwr_good`, `vtt_ok` and `vcc_ok` are all high. `drive_en` rises after exactly N qualified rising edges, where N = CLK_MHZ*ARM_US, and stays high while the block remains qualified.
- R3: The trip level is tcase_max+20, saturated at 255. The block trips when the unsigned 8-bit `temp_code` is greater than or equal to that level.
- R4: `thermtrip_n` is 0 exactly when the trip is latched and `drive_en` is 1. `clk_halt` is 1 exactly when the trip is latched and the block is qualified.
- R5: Once latched, the trip holds while the block stays qualified, even if `temp_code` drops below the level.
- R6: Dropping `pwr_good`, `vtt_ok` or `vcc_ok` deasserts `thermtrip_n` and `clk_halt` in the same cycle, and the latch is cleared at the next edge.
- R7: No trip is latched before arming. If the die is hot from power-up, the trip appears at the N-th qualified edge.
- R8: If the temperature reaches the level after arming, the trip appears at the next rising edge.
- R9: `drive_en` is 0 whenever `vtt_ok` or `vcc_ok` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| temp_code | input | 8 | Die temperature, unsigned °C |
| tcase_max | input | 8 | Maximum rated case temperature, unsigned °C |
| pwr_good | input | 1 | Power-good qualifier |
| vtt_ok | input | 1 | Bus supply valid |
| vcc_ok | input | 1 | Core supply valid |
| thermtrip_n | output | 1 | Active-low thermal trip |
| drive_en | output | 1 | Trip output drive enabled |
| clk_halt | output | 1 | Request to stop internal clocks |

## Verification
The bench sweeps every temperature code against case limits whose level lands low, in the middle, exactly at 255 and in saturation. A comparator that is strict instead of greater-or-equal, or one whose addition wraps, would then miss or invent trips at the boundary codes. Each power-up is checked cycle by cycle across the arming window. An off-by-one counter would enable the drive, or trip, one edge early or late. Loss of each qualifier on its own is checked against a hot, sticky trip: a latch that ignores a supply flag would keep asserting, and one that follows the temperature would release once the die cools.

// File: rtl/thermtrip_pkg.sv
package thermtrip_pkg;

    localparam int TEMP_W = 8;

    typedef struct packed {
        logic trip;
        logic drive;
    } trip_state_t;

    function automatic logic [TEMP_W-1:0] sat_level(input logic [TEMP_W-1:0] base,
                                                     input int unsigned margin);
        logic [TEMP_W:0] sum;
        sum = {1'b0, base} + (TEMP_W+1)'(margin);
        return sum[TEMP_W] ? {TEMP_W{1'b1}} : sum[TEMP_W-1:0];
    endfunction

endpackage

// File: rtl/tt_arm_timer.sv
module tt_arm_timer #(
    parameter int unsigned ARM_CYCLES = 999
) (
    input  logic clk,
    input  logic qual,
    output logic armed
);
    localparam int unsigned CW = $clog2(ARM_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!qual) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CW'(ARM_CYCLES)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign armed = qual && (st_q.cnt == CW'(ARM_CYCLES));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!qual)
        st_q.cnt <= CW'(ARM_CYCLES));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!qual)
        !armed |=> (st_q.cnt != '0));

endmodule

// File: rtl/tt_trip_core.sv
module tt_trip_core
    import thermtrip_pkg::*;
#(
    parameter int unsigned MARGIN = 20
) (
    input  logic              clk,
    input  logic              qual,
    input  logic              armed,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic [TEMP_W-1:0] tcase_max,
    output logic              trip,
    output logic              drive
);
    trip_state_t st_d, st_q;
    logic [TEMP_W-1:0] level;
    logic              hot;

    assign level = sat_level(tcase_max, MARGIN);
    assign hot   = (temp_code >= level);

    always_comb begin
        st_d = st_q;
        if (!qual) begin
            st_d.trip  = 1'b0;
            st_d.drive = 1'b0;
        end else begin
            st_d.drive = armed;
            st_d.trip  = st_q.trip || (armed && hot);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign trip  = st_q.trip && qual;
    assign drive = st_q.drive && qual;

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!qual)
        st_q.trip |=> st_q.trip);

    // R7
    no_early_trip_chk: assert property (@(posedge clk) disable iff (!qual)
        (!armed && !st_q.trip) |=> !st_q.trip);

    // R8
    hot_cause_chk: assert property (@(posedge clk) disable iff (!qual)
        (!st_q.trip ##1 st_q.trip) |-> $past(hot));

endmodule

// File: rtl/thermal_trip_latch.sv
module thermal_trip_latch
    import thermtrip_pkg::*;
#(
    parameter int unsigned CLK_MHZ = 100,
    parameter int unsigned ARM_US  = 10,
    parameter int unsigned MARGIN  = 20
) (
    input  logic              clk,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic [TEMP_W-1:0] tcase_max,
    input  logic              pwr_good,
    input  logic              vtt_ok,
    input  logic              vcc_ok,
    output logic              thermtrip_n,
    output logic              drive_en,
    output logic              clk_halt
);
    localparam int unsigned WINDOW     = CLK_MHZ * ARM_US;
    localparam int unsigned ARM_CYCLES = WINDOW - 1;

    logic qual, armed, trip, drive;

    assign qual = pwr_good && vtt_ok && vcc_ok;

    tt_arm_timer #(.ARM_CYCLES(ARM_CYCLES)) u_timer (
        .clk   (clk),
        .qual  (qual),
        .armed (armed)
    );

    tt_trip_core #(.MARGIN(MARGIN)) u_core (
        .clk       (clk),
        .qual      (qual),
        .armed     (armed),
        .temp_code (temp_code),
        .tcase_max (tcase_max),
        .trip      (trip),
        .drive     (drive)
    );

    assign drive_en    = drive;
    assign thermtrip_n = !(trip && drive);
    assign clk_halt    = trip;

    // R4
    halt_pair_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        !thermtrip_n |-> clk_halt);

    // R6
    supply_clear_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (!vtt_ok || !vcc_ok) |-> (thermtrip_n && !clk_halt));

    // R9
    drive_off_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        (!vtt_ok || !vcc_ok) |-> !drive_en);

endmodule

// File: tb/thermal_trip_latch_tb.sv
module thermal_trip_latch_tb;
    localparam int CLK_MHZ = 1;
    localparam int ARM_US  = 10;
    localparam int N       = CLK_MHZ * ARM_US;

    logic       clk = 1'b0;
    logic [7:0] temp_code = '0;
    logic [7:0] tcase_max = '0;
    logic       pwr_good = 1'b0;
    logic       vtt_ok = 1'b0;
    logic       vcc_ok = 1'b0;
    logic       thermtrip_n, drive_en, clk_halt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    thermal_trip_latch #(.CLK_MHZ(CLK_MHZ), .ARM_US(ARM_US), .MARGIN(20)) u_dut (
        .clk(clk), .temp_code(temp_code), .tcase_max(tcase_max),
        .pwr_good(pwr_good), .vtt_ok(vtt_ok), .vcc_ok(vcc_ok),
        .thermtrip_n(thermtrip_n), .drive_en(drive_en), .clk_halt(clk_halt)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int level_of(input int tc);
        return (tc + 20 > 255) ? 255 : tc + 20;
    endfunction

    // Power up with the given temperature; returns after edge N.
    task automatic power_up(input int t, input int tc, input bit full);
        pwr_good = 1'b0; vtt_ok = 1'b1; vcc_ok = 1'b1;
        temp_code = 8'(t); tcase_max = 8'(tc);
        step();
        #1;
        chk(!drive_en && thermtrip_n && !clk_halt, "R1 off while pg low",
            {drive_en, thermtrip_n, clk_halt}, 3'b010);
        pwr_good = 1'b1;
        for (int e = 1; e < N; e++) begin
            step();
            if (full || e == N - 1) begin
                chk(!drive_en, "R2 drive before window", drive_en, 0);
                chk(thermtrip_n, "R7 no trip before arming", thermtrip_n, 1);
            end
        end
        step();
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cases[6] = '{0, 50, 100, 235, 236, 255};
        int lvl;
        bit hot;

        // Reset state
        step();
        chk(!drive_en && thermtrip_n && !clk_halt, "R1 initial",
            {drive_en, thermtrip_n, clk_halt}, 3'b010);

        // Exhaustive temperature sweep per case limit (R3, R4, R7, R2)
        foreach (cases[i]) begin
            lvl = level_of(cases[i]);
            for (int t = 0; t < 256; t++) begin
                hot = (t >= lvl);
                power_up(t, cases[i], (t == 0));
                chk(drive_en, "R2 drive at window", drive_en, 1);
                chk(thermtrip_n == !hot, "R3 compare", thermtrip_n, !hot);
                chk(clk_halt == hot, "R4 halt follows trip", clk_halt, hot);
            end
        end

        // Sticky after cooling (R5), then each qualifier clears (R6, R9)
        for (int which = 0; which < 3; which++) begin
            power_up(200, 100, 1'b0);
            chk(!thermtrip_n, "R7 hot at power-up trips at N", thermtrip_n, 0);
            temp_code = 8'd0;
            for (int k = 0; k < 5; k++) begin
                step();
                chk(!thermtrip_n && clk_halt, "R5 sticky", thermtrip_n, 0);
            end
            if (which == 0) pwr_good = 1'b0;
            else if (which == 1) vtt_ok = 1'b0;
            else vcc_ok = 1'b0;
            #1;
            chk(thermtrip_n && !clk_halt, "R6 same-cycle clear", thermtrip_n, 1);
            chk(!drive_en, "R9 drive off on qualifier loss", drive_en, 0);
            step();
            pwr_good = 1'b1; vtt_ok = 1'b1; vcc_ok = 1'b1;
            #1;
            chk(thermtrip_n && !clk_halt && !drive_en, "R6 latch cleared",
                {thermtrip_n, clk_halt, drive_en}, 3'b100);
            step();
            chk(thermtrip_n, "R7 no immediate retrip", thermtrip_n, 1);
        end

        // Crossing after arming trips one edge later (R8)
        power_up(119, 100, 1'b0);
        chk(thermtrip_n, "R8 below level", thermtrip_n, 1);
        step();
        chk(thermtrip_n, "R8 still below", thermtrip_n, 1);
        temp_code = 8'd120;
        step();
        chk(!thermtrip_n && clk_halt, "R8 trip next edge", thermtrip_n, 0);

        // Still hot across a power-good drop: re-trips at edge N (R7)
        pwr_good = 1'b0;
        step();
        pwr_good = 1'b1;
        for (int e = 1; e < N; e++) step();
        chk(thermtrip_n, "R7 no retrip at N-1", thermtrip_n, 1);
        step();
        chk(!thermtrip_n, "R7 retrip at N", thermtrip_n, 0);

        // Supply invalid alone keeps drive off over many cycles (R9)
        vcc_ok = 1'b0;
        for (int k = 0; k < 2 * N; k++) step();
        chk(!drive_en && thermtrip_n, "R9 drive held off", drive_en, 0);
        vcc_ok = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule